// File: doc/BRIEF.md
# Ten-Lane Frame Packer with Package Trailer

The block takes one compacted frame per bunch crossing, each 8 to 16 bytes long, and lays the bytes end to end into a buffer whose rows are ten bytes wide. The buffer can then be drained at a steady one row per clock. A write pointer made of a row index and a lane index (0 to 9) moves forward by each frame's length. When the lane passes 9 it wraps to 0 and the row increments. A crossing flagged empty stores nothing. Every 256 consecutive crossings form a package. Packages alternate between two banks, and each package starts at row 0, lane 0 of its bank.

Readout of a package starts a fixed 64 clocks after its first crossing and emits its 256 rows in order, one per clock. Packages follow one another with no gap. Row 255 of every package is held back for a status trailer, so frame data can use at most 255 rows (2550 bytes). Bytes beyond that are dropped and counted as truncation. Space a package did not fill reads back as zero.

Top module: `lane_packer`

## Requirements
- R1: While reset is applied, and until the first row is due, `row_valid` is 0.
- R2: Byte k of a non-empty frame (bits 8k+7:8k of `frame_bytes`) is stored at linear position p+k of its package, where p is the position at the frame's start. Linear position q maps to row q/10, lane q%10. Lane j of an output row is carried on bits 8j+7:8j of `row_data`.
- R3: Each frame starts at the position where the previous frame of the package ended. The first crossing after reset, and every 256th crossing after it, opens a new package at row 0, lane 0.
- R4: A crossing with `xing_empty` high writes nothing and leaves the position unchanged.
- R5: Bytes whose linear position is 2550 or more are dropped, and the position then stays at row 255, lane 0. Every frame that loses at least one byte increments the package's truncation count, which saturates at 255. A frame that ends exactly at 2550 is not truncated.
- R6: Row 0 of a package appears with `row_valid` high just after the 65th clock edge counted from the edge that took the package's first crossing. Rows then follow in order, one per clock, 256 per package, with no gap between packages.
- R7: In rows 0 to 254, every byte at or beyond the package's final position reads as zero. This covers whole rows past it and the upper lanes of a partly filled row, even when an earlier package left data in that bank.
- R8: Row 255 is the trailer and is flagged by `row_is_trailer`. Its layout is: bits 7:0 the final row, bits 11:8 the final lane (next free position), bit 12 set when the count is non-zero, bits 20:13 the truncation count, and all other bits zero.
- R9: Writing a package does not disturb the readout of the previous package, which overlaps it for 64 clocks in the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one crossing per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xing_empty | input | 1 | Crossing carries no data |
| frame_len | input | 5 | Number of valid bytes in the frame (0 to 16) |
| frame_bytes | input | 128 | Compacted frame, byte k at bits 8k+7:8k |
| row_valid | output | 1 | An output row is present |
| row_data | output | 80 | Output row, lane j at bits 8j+7:8j |
| row_is_trailer | output | 1 | The current row is the package trailer |

## Verification
The bench builds the block with its default parameters: ten lanes, 256-row packages, 16-byte frames and a 64-clock readout delay. With these defaults a package of 16-byte frames overruns the 2550-byte limit after about 160 crossings. A crafted package lands exactly on row 255, lane 0. A package of 8-byte frames written into a bank that still holds full data from two packages earlier shows whether stale bytes are masked. Six packages alternate across both banks, so the 64-clock overlap between writing one bank and draining the other is exercised repeatedly.

// File: rtl/lpk_pkg.sv
package lpk_pkg;
  // Default geometry of the packer.
  localparam int unsigned LANES_DEF = 10;
  localparam int unsigned ROWS_DEF  = 256;
  localparam int unsigned MAXB_DEF  = 16;
  localparam int unsigned DELAY_DEF = 64;
  // Width of the per-package truncation counter.
  localparam int unsigned CNT_W     = 8;
endpackage

// File: rtl/lpk_advance.sv
// Mixed-radix position update: adds a frame length to (row, lane),
// carrying lanes into rows, saturating at the reserved trailer row.
module lpk_advance #(
  parameter int unsigned LANES = 10,
  parameter int unsigned ROWS  = 256,
  parameter int unsigned MAXB  = 16,
  parameter int unsigned CW    = 8
) (
  input  logic [$clog2(ROWS)-1:0]   cur_row,
  input  logic [$clog2(LANES)-1:0]  cur_lane,
  input  logic [CW-1:0]             cur_cnt,
  input  logic                      skip,
  input  logic [$clog2(MAXB+1)-1:0] len,
  output logic [$clog2(ROWS)-1:0]   nxt_row,
  output logic [$clog2(LANES)-1:0]  nxt_lane,
  output logic [CW-1:0]             nxt_cnt
);
  localparam int unsigned RW = $clog2(ROWS);
  localparam int unsigned LW = $clog2(LANES);
  localparam int unsigned SW = $clog2(LANES + MAXB);
  localparam int unsigned XW = RW + 2;

  logic [SW-1:0] sum;
  logic [SW-1:0] carry;
  logic [SW-1:0] rem;
  logic [XW-1:0] row_ext;
  logic          over;

  always_comb begin
    sum     = SW'(cur_lane) + SW'(len);
    carry   = sum / SW'(LANES);
    rem     = sum - carry * SW'(LANES);
    row_ext = XW'(cur_row) + XW'(carry);
    over    = (row_ext > XW'(ROWS - 1)) ||
              ((row_ext == XW'(ROWS - 1)) && (rem != '0));
    nxt_row  = cur_row;
    nxt_lane = cur_lane;
    nxt_cnt  = cur_cnt;
    if (!skip) begin
      if (over) begin
        nxt_row  = RW'(ROWS - 1);
        nxt_lane = '0;
        if (cur_cnt != '1) nxt_cnt = cur_cnt + 1'b1;
      end else begin
        nxt_row  = RW'(row_ext);
        nxt_lane = LW'(rem);
      end
    end
  end
endmodule

// File: rtl/lpk_lane.sv
// One byte lane of the buffer: two row-interleaved memories (even and odd
// rows) so that the two bytes a frame may place in this lane, always on
// consecutive rows, are stored in the same cycle. Assumes MAXB <= 2*LANES.
module lpk_lane #(
  parameter int unsigned LANE_ID = 0,
  parameter int unsigned LANES   = 10,
  parameter int unsigned ROWS    = 256,
  parameter int unsigned MAXB    = 16
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic                      wr_bank,
  input  logic [$clog2(ROWS)-1:0]   st_row,
  input  logic [$clog2(LANES)-1:0]  st_lane,
  input  logic [$clog2(MAXB+1)-1:0] len,
  input  logic [MAXB*8-1:0]         frame_bytes,
  input  logic                      rd_bank,
  input  logic [$clog2(ROWS)-1:0]   rd_row,
  output logic [7:0]                rd_byte
);
  localparam int unsigned RW    = $clog2(ROWS);
  localparam int unsigned KW    = $clog2(2 * LANES + 1);
  localparam int unsigned XW    = RW + 1;
  localparam int unsigned DEPTH = ROWS;

  logic [7:0]    mem_ev [DEPTH];
  logic [7:0]    mem_od [DEPTH];
  logic [KW-1:0] k_a, k_b;
  logic [XW-1:0] row_a, row_b;
  logic          we_a, we_b;
  logic [7:0]    dat_a, dat_b;
  logic          ev_we, od_we;
  logic [RW-1:0] ev_idx, od_idx;
  logic [7:0]    ev_dat, od_dat;

  always_comb begin
    if (int'(st_lane) <= int'(LANE_ID)) begin
      k_a   = KW'(int'(LANE_ID) - int'(st_lane));
      row_a = XW'(st_row);
    end else begin
      k_a   = KW'(int'(LANE_ID) + int'(LANES) - int'(st_lane));
      row_a = XW'(st_row) + 1'b1;
    end
    k_b   = k_a + KW'(LANES);
    row_b = row_a + 1'b1;
    dat_a = '0;
    dat_b = '0;
    for (int k = 0; k < int'(MAXB); k++) begin
      if (int'(k_a) == k) dat_a = frame_bytes[8*k +: 8];
      if (int'(k_b) == k) dat_b = frame_bytes[8*k +: 8];
    end
    we_a = wr_en && (int'(k_a) < int'(len)) && (row_a < XW'(ROWS - 1));
    we_b = wr_en && (int'(k_b) < int'(len)) && (row_b < XW'(ROWS - 1));
    if (!row_a[0]) begin
      ev_we = we_a; ev_idx = {wr_bank, row_a[RW-1:1]}; ev_dat = dat_a;
      od_we = we_b; od_idx = {wr_bank, row_b[RW-1:1]}; od_dat = dat_b;
    end else begin
      od_we = we_a; od_idx = {wr_bank, row_a[RW-1:1]}; od_dat = dat_a;
      ev_we = we_b; ev_idx = {wr_bank, row_b[RW-1:1]}; ev_dat = dat_b;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_we) mem_ev[ev_idx] <= ev_dat;
    if (od_we) mem_od[od_idx] <= od_dat;
  end

  assign rd_byte = rd_row[0] ? mem_od[{rd_bank, rd_row[RW-1:1]}]
                             : mem_ev[{rd_bank, rd_row[RW-1:1]}];
endmodule

// File: rtl/lane_packer.sv
module lane_packer
  import lpk_pkg::*;
#(
  parameter int unsigned LANES    = LANES_DEF,
  parameter int unsigned ROWS     = ROWS_DEF,
  parameter int unsigned MAXB     = MAXB_DEF,
  parameter int unsigned RD_DELAY = DELAY_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xing_empty,
  input  logic [$clog2(MAXB+1)-1:0] frame_len,
  input  logic [MAXB*8-1:0]         frame_bytes,
  output logic                      row_valid,
  output logic [LANES*8-1:0]        row_data,
  output logic                      row_is_trailer
);
  localparam int unsigned RW = $clog2(ROWS);
  localparam int unsigned LW = $clog2(LANES);
  localparam int unsigned CW = CNT_W;
  localparam int unsigned DW = LANES * 8;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // Write-side state.
  logic [RW-1:0] slot_q, slot_d;
  logic          wbank_q, wbank_d;
  logic [RW-1:0] fill_row_q [2];
  logic [RW-1:0] fill_row_d [2];
  logic [LW-1:0] fill_lane_q [2];
  logic [LW-1:0] fill_lane_d [2];
  logic [CW-1:0] fill_cnt_q [2];
  logic [CW-1:0] fill_cnt_d [2];
  logic [RW-1:0] st_row, nx_row;
  logic [LW-1:0] st_lane, nx_lane;
  logic [CW-1:0] st_cnt, nx_cnt;

  // Read-side state.
  logic          rd_run_q, rd_run_d;
  logic [RW-1:0] rd_row_q, rd_row_d;
  logic          rd_bank_q, rd_bank_d;
  logic          vld_q, vld_d;
  logic          trl_q, trl_d;
  logic [DW-1:0] dat_q, dat_d;
  logic [7:0]    lane_byte [LANES];
  logic [RW-1:0] r_row;
  logic [LW-1:0] r_lane;
  logic [CW-1:0] r_cnt;

  always_comb begin
    if (slot_q == '0) begin
      st_row = '0; st_lane = '0; st_cnt = '0;
    end else begin
      st_row  = fill_row_q[wbank_q];
      st_lane = fill_lane_q[wbank_q];
      st_cnt  = fill_cnt_q[wbank_q];
    end
  end

  lpk_advance #(.LANES(LANES), .ROWS(ROWS), .MAXB(MAXB), .CW(CW)) u_adv (
    .cur_row (st_row),
    .cur_lane(st_lane),
    .cur_cnt (st_cnt),
    .skip    (xing_empty),
    .len     (frame_len),
    .nxt_row (nx_row),
    .nxt_lane(nx_lane),
    .nxt_cnt (nx_cnt)
  );

  for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
    lpk_lane #(.LANE_ID(j), .LANES(LANES), .ROWS(ROWS), .MAXB(MAXB)) u_lane (
      .clk        (clk),
      .wr_en      (rst_i_n && !xing_empty),
      .wr_bank    (wbank_q),
      .st_row     (st_row),
      .st_lane    (st_lane),
      .len        (frame_len),
      .frame_bytes(frame_bytes),
      .rd_bank    (rd_bank_q),
      .rd_row     (rd_row_q),
      .rd_byte    (lane_byte[j])
    );
  end

  // Next state.
  always_comb begin
    slot_d      = slot_q + 1'b1;
    wbank_d     = (slot_q == RW'(ROWS - 1)) ? ~wbank_q : wbank_q;
    fill_row_d  = fill_row_q;
    fill_lane_d = fill_lane_q;
    fill_cnt_d  = fill_cnt_q;
    fill_row_d[wbank_q]  = nx_row;
    fill_lane_d[wbank_q] = nx_lane;
    fill_cnt_d[wbank_q]  = nx_cnt;

    rd_run_d  = rd_run_q || (slot_q == RW'(RD_DELAY - 1));
    rd_row_d  = rd_run_q ? rd_row_q + 1'b1 : rd_row_q;
    rd_bank_d = (rd_run_q && (rd_row_q == RW'(ROWS - 1))) ? ~rd_bank_q : rd_bank_q;

    r_row  = fill_row_q[rd_bank_q];
    r_lane = fill_lane_q[rd_bank_q];
    r_cnt  = fill_cnt_q[rd_bank_q];
    vld_d  = rd_run_q;
    trl_d  = rd_run_q && (rd_row_q == RW'(ROWS - 1));
    dat_d  = '0;
    if (rd_run_q) begin
      if (rd_row_q == RW'(ROWS - 1)) begin
        dat_d[RW-1:0]        = r_row;
        dat_d[RW+LW-1:RW]    = r_lane;
        dat_d[RW+LW]         = (r_cnt != '0);
        dat_d[RW+LW+1 +: CW] = r_cnt;
      end else begin
        for (int j = 0; j < int'(LANES); j++) begin
          if ((rd_row_q < r_row) || ((rd_row_q == r_row) && (LW'(j) < r_lane)))
            dat_d[8*j +: 8] = lane_byte[j];
        end
      end
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      slot_q    <= '0;
      wbank_q   <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        fill_row_q[b]  <= '0;
        fill_lane_q[b] <= '0;
        fill_cnt_q[b]  <= '0;
      end
      rd_run_q  <= 1'b0;
      rd_row_q  <= '0;
      rd_bank_q <= 1'b0;
      vld_q     <= 1'b0;
      trl_q     <= 1'b0;
      dat_q     <= '0;
    end else begin
      slot_q      <= slot_d;
      wbank_q     <= wbank_d;
      fill_row_q  <= fill_row_d;
      fill_lane_q <= fill_lane_d;
      fill_cnt_q  <= fill_cnt_d;
      rd_run_q    <= rd_run_d;
      rd_row_q    <= rd_row_d;
      rd_bank_q   <= rd_bank_d;
      vld_q       <= vld_d;
      trl_q       <= trl_d;
      dat_q       <= dat_d;
    end
  end

  assign row_valid      = vld_q;
  assign row_is_trailer = trl_q;
  assign row_data       = dat_q;
endmodule

// File: rtl/lane_packer_chk.sv
module lane_packer_chk #(
  parameter int unsigned LANES = 10,
  parameter int unsigned ROWS  = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               row_valid,
  input logic               row_is_trailer,
  input logic [LANES*8-1:0] row_data
);
  localparam int unsigned RW = $clog2(ROWS);
  localparam int unsigned LW = $clog2(LANES);
  localparam int unsigned CW = 8;
  localparam int unsigned TOP = RW + LW + 1 + CW;

  logic [RW-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= '0;
    else if (row_valid) seen_q <= seen_q + 1'b1;
  end

  // R6: once rows flow they never pause.
  assert_stream_continuous_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |=> row_valid);

  // R6: the trailer is exactly every ROWS-th row.
  assert_trailer_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> (row_is_trailer == (seen_q == RW'(ROWS - 1))));

  // R8: trailer flag only on a valid row, and never twice in a row.
  assert_trailer_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    row_is_trailer |-> row_valid);
  assert_trailer_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    row_is_trailer |=> !row_is_trailer);

  // R8: unused trailer bits are zero; flag agrees with the count.
  assert_trailer_layout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    row_is_trailer |-> ((row_data[LANES*8-1:TOP] == '0) &&
                        (row_data[RW+LW] == (row_data[RW+LW+1 +: CW] != '0))));

  // R5: the reported position never passes the reserved row.
  assert_fill_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_is_trailer |-> ((row_data[RW+LW-1:RW] < LW'(LANES)) &&
                        ((row_data[RW-1:0] != RW'(ROWS - 1)) || (row_data[RW+LW-1:RW] == '0))));
endmodule

bind lane_packer lane_packer_chk #(.LANES(LANES), .ROWS(ROWS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .row_valid     (row_valid),
  .row_is_trailer(row_is_trailer),
  .row_data      (row_data)
);

// File: tb/lane_packer_test.sv
module lane_packer_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LANES    = 10;
  localparam int ROWS     = 256;
  localparam int MAXB     = 16;
  localparam int RD_DELAY = 64;
  localparam int NPKG     = 6;
  localparam int TOT      = NPKG * ROWS;
  localparam int CAP      = (ROWS - 1) * LANES;
  localparam int NW       = $clog2(MAXB + 1);
  localparam int DW       = LANES * 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic            xing_empty;
  logic [NW-1:0]   frame_len;
  logic [MAXB*8-1:0] frame_bytes;
  logic            row_valid;
  logic [DW-1:0]   row_data;
  logic            row_is_trailer;

  lane_packer #(.LANES(LANES), .ROWS(ROWS), .MAXB(MAXB), .RD_DELAY(RD_DELAY)) uut (
    .clk(clk), .rst_n(rst_n), .xing_empty(xing_empty), .frame_len(frame_len),
    .frame_bytes(frame_bytes), .row_valid(row_valid), .row_data(row_data),
    .row_is_trailer(row_is_trailer)
  );

  int checks;
  int errors;
  int ngot;
  bit done;
  logic [DW-1:0] exp_rows [TOT];
  logic [DW-1:0] got_rows [TOT];
  logic          got_trl  [TOT];
  logic [DW-1:0] img [ROWS];
  int m_lin;
  int m_cnt;
  int pkg_mode [NPKG];

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_row(input string tag, input int idx, input logic [DW-1:0] act,
                           input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: row %0d actual %h expected %h", tag, idx, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < ROWS; r++) img[r] = '0;
    m_lin = 0;
    m_cnt = 0;
  endtask

  // Linear-address model of the packing rules (R2-R5).
  task automatic model_frame(input bit emp, input int len, input logic [MAXB*8-1:0] b);
    if (emp) return;
    for (int k = 0; k < len; k++) begin
      int lin;
      lin = m_lin + k;
      if (lin < CAP) img[lin / LANES][8 * (lin % LANES) +: 8] = b[8*k +: 8];
    end
    if (m_lin + len > CAP) begin
      m_lin = CAP;
      if (m_cnt < 255) m_cnt++;
    end else begin
      m_lin = m_lin + len;
    end
  endtask

  // Trailer per R8.
  task automatic model_close(input int p);
    logic [DW-1:0] t;
    for (int r = 0; r < ROWS - 1; r++) exp_rows[p*ROWS + r] = img[r];
    t = '0;
    t[7:0]   = 8'(m_lin / LANES);
    t[11:8]  = 4'(m_lin % LANES);
    t[12]    = (m_cnt != 0);
    t[20:13] = 8'(m_cnt);
    exp_rows[p*ROWS + ROWS - 1] = t;
  endtask

  task automatic make_frame(input int mode, input int slot, output bit emp, output int len);
    emp = 1'b0;
    len = 8 + int'($urandom % 9);
    if (slot >= ROWS - 3) emp = 1'b1;
    else begin
      case (mode)
        0: if ($urandom % 50 == 0) emp = 1'b1;
        1: len = 16;
        2: emp = 1'b1;
        3: len = 8;
        4: begin
          if ($urandom % 10 == 0) emp = 1'b1;
          else if ($urandom % 2 == 0) len = 16;
        end
        5: begin
          if (slot < 158) len = 16;
          else if (slot < 160) len = 11;
          else emp = 1'b1;
        end
        default: emp = 1'b1;
      endcase
    end
  endtask

  function automatic string row_tag(input int idx);
    if (idx % ROWS == ROWS - 1) return "R8";
    case (pkg_mode[idx / ROWS])
      0: return "R2";
      1: return "R5";
      2: return "R4";
      3: return "R7";
      4: return "R9";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    done = 1'b0;
    checks = 0; errors = 0; ngot = 0;
    rst_n = 1'b0; xing_empty = 1'b1; frame_len = '0; frame_bytes = '0;
    // p0 random, p1 overrun, p2 all empty, p3 short frames over stale bank,
    // p4 mixed with many empties, p5 exact fill to the reserved row.
    pkg_mode[0] = 0; pkg_mode[1] = 1; pkg_mode[2] = 2;
    pkg_mode[3] = 3; pkg_mode[4] = 4; pkg_mode[5] = 5;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R1", row_valid, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    for (int e = 0; e < TOT + RD_DELAY + 4; e++) begin
      int slot;
      int p;
      int len;
      bit emp;
      @(negedge clk);
      if (e == 0) check_bit("R1", row_valid, 1'b0);
      if (e == RD_DELAY) check_bit("R1", row_valid, 1'b0);
      if (e == RD_DELAY + 1) check_bit("R6", row_valid, 1'b1);
      if (row_valid && ngot < TOT) begin
        got_rows[ngot] = row_data;
        got_trl[ngot]  = row_is_trailer;
        ngot++;
      end
      slot = e % ROWS;
      p    = e / ROWS;
      if (slot == 0 && e > 0) begin
        model_close(p - 1);
        model_reset();
      end
      make_frame((p < NPKG) ? pkg_mode[p] : 9, slot, emp, len);
      for (int w = 0; w < MAXB / 4; w++) frame_bytes[32*w +: 32] = $urandom;
      xing_empty = emp;
      frame_len  = NW'(len);
      model_frame(emp, len, frame_bytes);
    end
    checks++;
    if (ngot != TOT) begin
      errors++;
      $display("FAIL R6: actual %0d rows expected %0d rows", ngot, TOT);
    end
    for (int i = 0; i < ngot; i++) begin
      check_bit("R6", got_trl[i], (i % ROWS == ROWS - 1));
      check_row(row_tag(i), i, got_rows[i], exp_rows[i]);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule